// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects rising edges from 64 interrupt sources into pending bits and reports them to a processor on two request lines. The fast line serves sources whose priority is 0 or 1. The normal line serves sources with priority 2 to 7. Each source has an enable bit and a 3-bit priority. A pending bit stays set until software clears it by writing a 1 to it.

For the normal line, the block also gives an entry value. This value is a software-chosen base address plus four times (winning source index + 1). The winner is the enabled, pending, normal-path source with the numerically smallest priority. A tie goes to the lower source index. With a base of zero, a handler recovers the index as (entry >> 2) - 1.

The host reaches every register through a simple 32-bit bus: byte address, write strobe, read strobe, write data and a registered read-data port.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset, every register reads 0 and both request outputs are low.
- R2: A source sets its pending bit only on a 0-to-1 change of its input. If the input stays high after a clear, the bit is not set again.
- R3: When an edge is captured, the source's priority at that moment picks the path. Priority 0 or 1 sets the fast pending bit; priority 2 to 7 sets the normal pending bit. Fast pending words are at 0x00 and 0x04, normal pending words at 0x08 and 0x0C. Bit b of word w is source 32w+b.
- R4: Writing a pending word clears each bit written as 1 and keeps each bit written as 0. An edge captured in the same cycle as a clear of that bit leaves the bit set.
- R5: Enable words are at 0x18 and 0x1C, with bit b of word w for source 32w+b. The fast output is the OR of fast pending bits ANDed with their enables. The normal output is the same OR for normal pending bits. Both outputs follow an enable write from the next clock edge.
- R6: Priority words are at 0x30 to 0x4C. The word at 0x30+4r holds source 8r+n in bits [4n+2:4n]. Bit 4n+3 always reads as 0.
- R7: The entry word at 0x14 reads as base + ((i+1)<<2), using 32-bit wraparound addition. Here i is the enabled, normal-pending source with the smallest priority value, and the lowest index among equals. Fast-pending sources take no part.
- R8: When no enabled normal-pending source exists, the entry word reads as the base held at 0x24.
- R9: Writes to the entry word have no effect. The control word at 0x20 stores its low 2 bits, reads its other bits as 0, and does not change arbitration.
- R10: Read data changes only in the cycle after a read strobe. It then carries the register value at that clock edge. Unmapped or misaligned addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 64 | Interrupt source inputs, edge-sensitive |
| addr_i | input | 8 | Register byte address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| fast_req_o | output | 1 | Fast-path request line |
| norm_req_o | output | 1 | Normal-path request line |

## Verification
The edge-to-pending properties assume each source input is synchronous to the clock and holds a value for at least one full cycle. The stimulus therefore changes sources only at the falling edge and keeps each pulse high for a whole cycle. The pending-hold properties assume a bit can fall only after a bus write to its word. For that reason, the bench never issues a write and a read in the same cycle. Random traffic draws sparse source masks, full enable and priority words, and random clear patterns. Directed cases cover same-cycle edge and clear, held-high inputs, priority ties and a nonzero base.

// File: rtl/pvi_pkg.sv
package pvi_pkg;

    localparam int BUS_W     = 32;
    localparam int NIB_W     = 4;
    localparam int PRIO_PER_WORD = BUS_W / NIB_W;

    // byte offsets of each register group
    localparam int OFS_FAST  = 'h00;
    localparam int OFS_NORM  = 'h08;
    localparam int OFS_ENTRY = 'h14;
    localparam int OFS_EN    = 'h18;
    localparam int OFS_CTRL  = 'h20;
    localparam int OFS_BASE  = 'h24;
    localparam int OFS_PRIO  = 'h30;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_FAST,
        SEL_NORM,
        SEL_ENTRY,
        SEL_EN,
        SEL_CTRL,
        SEL_BASE,
        SEL_PRIO
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e    sel;
        logic [3:0]  idx;
    } reg_dec_t;

    function automatic reg_dec_t pvi_decode(input int a, input int nbank, input int nprio);
        reg_dec_t d;
        d.sel = SEL_NONE;
        d.idx = '0;
        if ((a % 4) == 0) begin
            if (a >= OFS_FAST && a < OFS_FAST + 4 * nbank) begin
                d.sel = SEL_FAST;
                d.idx = 4'((a - OFS_FAST) / 4);
            end else if (a >= OFS_NORM && a < OFS_NORM + 4 * nbank) begin
                d.sel = SEL_NORM;
                d.idx = 4'((a - OFS_NORM) / 4);
            end else if (a == OFS_ENTRY) begin
                d.sel = SEL_ENTRY;
            end else if (a >= OFS_EN && a < OFS_EN + 4 * nbank) begin
                d.sel = SEL_EN;
                d.idx = 4'((a - OFS_EN) / 4);
            end else if (a == OFS_CTRL) begin
                d.sel = SEL_CTRL;
            end else if (a == OFS_BASE) begin
                d.sel = SEL_BASE;
            end else if (a >= OFS_PRIO && a < OFS_PRIO + 4 * nprio) begin
                d.sel = SEL_PRIO;
                d.idx = 4'((a - OFS_PRIO) / 4);
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/pvi_pend.sv
// Edge capture and pending storage, one slice per source.
module pvi_pend #(
    parameter int NSRC     = 64,
    parameter int PW       = 3,
    parameter int FAST_MAX = 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NSRC-1:0]    src_i,
    input  logic [NSRC*PW-1:0] prio_i,
    input  logic [NSRC-1:0]    fast_clr_i,
    input  logic [NSRC-1:0]    norm_clr_i,
    output logic [NSRC-1:0]    fast_pend_o,
    output logic [NSRC-1:0]    norm_pend_o
);

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        logic src_q;
        logic fast_q;
        logic norm_q;
        logic rise;
        logic to_fast;

        assign rise    = src_i[s] & ~src_q;
        assign to_fast = (prio_i[s*PW +: PW] <= PW'(FAST_MAX));

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                src_q  <= 1'b0;
                fast_q <= 1'b0;
                norm_q <= 1'b0;
            end else begin
                src_q  <= src_i[s];
                // a fresh edge outranks a clear in the same cycle
                fast_q <= (fast_q & ~fast_clr_i[s]) | (rise & to_fast);
                norm_q <= (norm_q & ~norm_clr_i[s]) | (rise & ~to_fast);
            end
        end

        assign fast_pend_o[s] = fast_q;
        assign norm_pend_o[s] = norm_q;
    end

endmodule

// File: rtl/pvi_arb.sv
// Binary tournament: smallest priority wins, left (lower index) wins ties.
module pvi_arb #(
    parameter int NSRC = 64,
    parameter int PW   = 3,
    localparam int IW  = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]    cand_i,
    input  logic [NSRC*PW-1:0] prio_i,
    output logic               found_o,
    output logic [IW-1:0]      idx_o
);

    localparam int NODES = 2 * NSRC - 1;

    logic          node_v [NODES];
    logic [PW-1:0] node_p [NODES];
    logic [IW-1:0] node_i [NODES];

    for (genvar k = 0; k < NSRC; k++) begin : g_leaf
        assign node_v[NSRC-1+k] = cand_i[k];
        assign node_p[NSRC-1+k] = prio_i[k*PW +: PW];
        assign node_i[NSRC-1+k] = IW'(k);
    end

    for (genvar n = 0; n < NSRC - 1; n++) begin : g_node
        logic pick_l;
        assign pick_l    = node_v[2*n+1] &&
                           (!node_v[2*n+2] || node_p[2*n+1] <= node_p[2*n+2]);
        assign node_v[n] = node_v[2*n+1] | node_v[2*n+2];
        assign node_p[n] = pick_l ? node_p[2*n+1] : node_p[2*n+2];
        assign node_i[n] = pick_l ? node_i[2*n+1] : node_i[2*n+2];
    end

    assign found_o = node_v[0];
    assign idx_o   = node_i[0];

endmodule

// File: rtl/pvi_regs.sv
// Register storage, write decode, clear masks and registered read port.
module pvi_regs
    import pvi_pkg::*;
#(
    parameter int NSRC   = 64,
    parameter int PW     = 3,
    parameter int CTRL_W = 2,
    parameter int AW     = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [AW-1:0]      addr_i,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic [BUS_W-1:0]   wdata_i,
    input  logic [NSRC-1:0]    fast_pend_i,
    input  logic [NSRC-1:0]    norm_pend_i,
    input  logic [BUS_W-1:0]   entry_i,
    output logic [NSRC-1:0]    en_o,
    output logic [NSRC*PW-1:0] prio_o,
    output logic [BUS_W-1:0]   base_o,
    output logic [NSRC-1:0]    fast_clr_o,
    output logic [NSRC-1:0]    norm_clr_o,
    output logic [BUS_W-1:0]   rdata_o
);

    localparam int NBANK = NSRC / BUS_W;
    localparam int NPRIO = NSRC / PRIO_PER_WORD;
    localparam int PSLICE = PRIO_PER_WORD * PW;

    reg_dec_t          dec;
    logic [CTRL_W-1:0] ctrl_q;
    logic [BUS_W-1:0]  base_q;
    logic [BUS_W-1:0]  rd_word;
    logic [BUS_W-1:0]  rdata_q;

    assign dec = pvi_decode(int'(addr_i), NBANK, NPRIO);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [BUS_W-1:0] en_q;
        logic             hit_fast;
        logic             hit_norm;
        logic             hit_en;

        assign hit_fast = wr_en_i && dec.sel == SEL_FAST && dec.idx == 4'(b);
        assign hit_norm = wr_en_i && dec.sel == SEL_NORM && dec.idx == 4'(b);
        assign hit_en   = wr_en_i && dec.sel == SEL_EN   && dec.idx == 4'(b);

        assign fast_clr_o[b*BUS_W +: BUS_W] = hit_fast ? wdata_i : '0;
        assign norm_clr_o[b*BUS_W +: BUS_W] = hit_norm ? wdata_i : '0;

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                en_q <= '0;
            end else if (hit_en) begin
                en_q <= wdata_i;
            end
        end

        assign en_o[b*BUS_W +: BUS_W] = en_q;
    end

    for (genvar r = 0; r < NPRIO; r++) begin : g_prio
        logic [PSLICE-1:0] p_q;
        logic              hit;

        assign hit = wr_en_i && dec.sel == SEL_PRIO && dec.idx == 4'(r);

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                p_q <= '0;
            end else if (hit) begin
                for (int n = 0; n < PRIO_PER_WORD; n++) begin
                    p_q[n*PW +: PW] <= wdata_i[n*NIB_W +: PW];
                end
            end
        end

        assign prio_o[r*PSLICE +: PSLICE] = p_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q <= '0;
            base_q <= '0;
        end else if (wr_en_i) begin
            if (dec.sel == SEL_CTRL) ctrl_q <= wdata_i[CTRL_W-1:0];
            if (dec.sel == SEL_BASE) base_q <= wdata_i;
        end
    end

    always_comb begin
        rd_word = '0;
        unique case (dec.sel)
            SEL_FAST:  rd_word = fast_pend_i[int'(dec.idx)*BUS_W +: BUS_W];
            SEL_NORM:  rd_word = norm_pend_i[int'(dec.idx)*BUS_W +: BUS_W];
            SEL_EN:    rd_word = en_o[int'(dec.idx)*BUS_W +: BUS_W];
            SEL_ENTRY: rd_word = entry_i;
            SEL_CTRL:  rd_word[CTRL_W-1:0] = ctrl_q;
            SEL_BASE:  rd_word = base_q;
            SEL_PRIO: begin
                for (int n = 0; n < PRIO_PER_WORD; n++) begin
                    rd_word[n*NIB_W +: PW] = prio_o[(int'(dec.idx)*PRIO_PER_WORD + n)*PW +: PW];
                end
            end
            default:   rd_word = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rdata_q <= '0;
        end else if (rd_en_i) begin
            rdata_q <= rd_word;
        end
    end

    assign base_o  = base_q;
    assign rdata_o = rdata_q;

endmodule

// File: rtl/prio_vec_intc.sv
// Top: edge capture, register file, normal-path arbiter and entry formation.
module prio_vec_intc
    import pvi_pkg::*;
#(
    parameter int NSRC     = 64,
    parameter int PW       = 3,
    parameter int FAST_MAX = 1,
    parameter int CTRL_W   = 2,
    parameter int AW       = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NSRC-1:0]   src_i,
    input  logic [AW-1:0]     addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [BUS_W-1:0]  wdata_i,
    output logic [BUS_W-1:0]  rdata_o,
    output logic              fast_req_o,
    output logic              norm_req_o
);

    localparam int IW = $clog2(NSRC);

    logic [NSRC-1:0]    fast_pend_q;
    logic [NSRC-1:0]    norm_pend_q;
    logic [NSRC-1:0]    fast_clr;
    logic [NSRC-1:0]    norm_clr;
    logic [NSRC-1:0]    en_q;
    logic [NSRC*PW-1:0] prio_flat;
    logic [BUS_W-1:0]   base_q;
    logic [BUS_W-1:0]   entry_w;
    logic [NSRC-1:0]    cand;
    logic               win_found;
    logic [IW-1:0]      win_idx;

    pvi_pend #(
        .NSRC     (NSRC),
        .PW       (PW),
        .FAST_MAX (FAST_MAX)
    ) u_pend (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .src_i       (src_i),
        .prio_i      (prio_flat),
        .fast_clr_i  (fast_clr),
        .norm_clr_i  (norm_clr),
        .fast_pend_o (fast_pend_q),
        .norm_pend_o (norm_pend_q)
    );

    pvi_regs #(
        .NSRC   (NSRC),
        .PW     (PW),
        .CTRL_W (CTRL_W),
        .AW     (AW)
    ) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .addr_i      (addr_i),
        .wr_en_i     (wr_en_i),
        .rd_en_i     (rd_en_i),
        .wdata_i     (wdata_i),
        .fast_pend_i (fast_pend_q),
        .norm_pend_i (norm_pend_q),
        .entry_i     (entry_w),
        .en_o        (en_q),
        .prio_o      (prio_flat),
        .base_o      (base_q),
        .fast_clr_o  (fast_clr),
        .norm_clr_o  (norm_clr),
        .rdata_o     (rdata_o)
    );

    // enable gates arbitration combinationally: a cleared enable drops out at once
    assign cand = norm_pend_q & en_q;

    pvi_arb #(
        .NSRC (NSRC),
        .PW   (PW)
    ) u_arb (
        .cand_i  (cand),
        .prio_i  (prio_flat),
        .found_o (win_found),
        .idx_o   (win_idx)
    );

    assign entry_w = win_found
                   ? base_q + ((BUS_W'(win_idx) + BUS_W'(1)) << 2)
                   : base_q;

    assign fast_req_o = |(fast_pend_q & en_q);
    assign norm_req_o = |cand;

endmodule

// File: rtl/pvi_checker.sv
module pvi_checker
    import pvi_pkg::*;
#(
    parameter int NSRC     = 64,
    parameter int PW       = 3,
    parameter int FAST_MAX = 1,
    parameter int AW       = 8
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [NSRC-1:0]    src_i,
    input logic [AW-1:0]      addr_i,
    input logic               wr_en_i,
    input logic               rd_en_i,
    input logic [BUS_W-1:0]   rdata_o,
    input logic               fast_req_o,
    input logic               norm_req_o,
    input logic [NSRC-1:0]    fast_pend,
    input logic [NSRC-1:0]    norm_pend,
    input logic [NSRC-1:0]    en,
    input logic [NSRC*PW-1:0] prio,
    input logic [BUS_W-1:0]   base,
    input logic [BUS_W-1:0]   entry
);

    localparam int NBANK = NSRC / BUS_W;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        // R2: a pending bit rises only after its input was seen high
        a_r2_fast_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(fast_pend[s]) |-> $past(src_i[s]));
        a_r2_norm_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(norm_pend[s]) |-> $past(src_i[s]));
        // R3: path chosen by priority at capture
        a_r3_fast_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(fast_pend[s]) |-> ($past(prio[s*PW +: PW]) <= PW'(FAST_MAX)));
        a_r3_norm_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(norm_pend[s]) |-> ($past(prio[s*PW +: PW]) > PW'(FAST_MAX)));
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        // R4: bits fall only after a write to their own word
        a_r4_fast_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !($past(wr_en_i) && $past(addr_i) == AW'(OFS_FAST + 4 * b))
            |-> (($past(fast_pend[b*BUS_W +: BUS_W]) & ~fast_pend[b*BUS_W +: BUS_W]) == '0));
        a_r4_norm_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !($past(wr_en_i) && $past(addr_i) == AW'(OFS_NORM + 4 * b))
            |-> (($past(norm_pend[b*BUS_W +: BUS_W]) & ~norm_pend[b*BUS_W +: BUS_W]) == '0));
    end

    // R5: nothing requests while every enable is off
    a_r5_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en == '0) |-> (!fast_req_o && !norm_req_o));

    // R7: an active normal request always moves the entry off the base
    a_r7_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        norm_req_o |-> (entry != base));

    // R8: idle normal path gives the bare base
    a_r8_idle_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !norm_req_o |-> (entry == base));

    // R10: read data moves only after a read strobe
    a_r10_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(rd_en_i) |-> $stable(rdata_o));

endmodule

bind prio_vec_intc pvi_checker #(
    .NSRC     (NSRC),
    .PW       (PW),
    .FAST_MAX (FAST_MAX),
    .AW       (AW)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (src_i),
    .addr_i     (addr_i),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .rdata_o    (rdata_o),
    .fast_req_o (fast_req_o),
    .norm_req_o (norm_req_o),
    .fast_pend  (fast_pend_q),
    .norm_pend  (norm_pend_q),
    .en         (en_q),
    .prio       (prio_flat),
    .base       (base_q),
    .entry      (entry_w)
);

// File: tb/sim_prio_vec_intc.sv
`timescale 1ns/1ps
module sim_prio_vec_intc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic        re = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        fq;
    logic        nq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [63:0] m_fast = '0;
    logic [63:0] m_norm = '0;
    logic [63:0] m_en = '0;
    logic [2:0]  m_prio [64];
    logic [31:0] m_base = '0;
    logic [1:0]  m_ctrl = '0;

    always #4 clk = ~clk;

    prio_vec_intc u0 (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .src_i      (src),
        .addr_i     (addr),
        .wr_en_i    (we),
        .rd_en_i    (re),
        .wdata_i    (wdata),
        .rdata_o    (rdata),
        .fast_req_o (fq),
        .norm_req_o (nq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_entry();
        bit         found = 1'b0;
        logic [2:0] bp = '0;
        int         bi = 0;
        for (int s = 0; s < 64; s++) begin
            if (m_norm[s] && m_en[s] && (!found || m_prio[s] < bp)) begin
                found = 1'b1;
                bp = m_prio[s];
                bi = s;
            end
        end
        return found ? m_base + ((32'(bi) + 32'd1) << 2) : m_base;
    endfunction

    function automatic logic [31:0] exp_word(input logic [7:0] a);
        logic [31:0] v = '0;
        if (a == 8'h00 || a == 8'h04) v = m_fast[a[2]*32 +: 32];
        else if (a == 8'h08 || a == 8'h0C) v = m_norm[a[2]*32 +: 32];
        else if (a == 8'h14) v = exp_entry();
        else if (a == 8'h18 || a == 8'h1C) v = m_en[a[2]*32 +: 32];
        else if (a == 8'h20) v = {30'b0, m_ctrl};
        else if (a == 8'h24) v = m_base;
        else if (a >= 8'h30 && a <= 8'h4C && a[1:0] == 2'b00) begin
            for (int n = 0; n < 8; n++) v[n*4 +: 3] = m_prio[int'(a - 8'h30) * 2 + n];
        end
        return v;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; re = 1'b1;
        @(negedge clk);
        re = 1'b0;
        d = rdata;
    endtask

    task automatic model_wr(input logic [7:0] a, input logic [31:0] d);
        if (a == 8'h00 || a == 8'h04) m_fast[a[2]*32 +: 32] = m_fast[a[2]*32 +: 32] & ~d;
        else if (a == 8'h08 || a == 8'h0C) m_norm[a[2]*32 +: 32] = m_norm[a[2]*32 +: 32] & ~d;
        else if (a == 8'h18 || a == 8'h1C) m_en[a[2]*32 +: 32] = d;
        else if (a == 8'h20) m_ctrl = d[1:0];
        else if (a == 8'h24) m_base = d;
        else if (a >= 8'h30 && a <= 8'h4C && a[1:0] == 2'b00) begin
            for (int n = 0; n < 8; n++) m_prio[int'(a - 8'h30) * 2 + n] = d[n*4 +: 3];
        end
    endtask

    task automatic mwr(input logic [7:0] a, input logic [31:0] d);
        wr(a, d);
        model_wr(a, d);
    endtask

    task automatic capture(input logic [63:0] m);
        for (int s = 0; s < 64; s++) begin
            if (m[s]) begin
                if (m_prio[s] <= 3'd1) m_fast[s] = 1'b1;
                else m_norm[s] = 1'b1;
            end
        end
    endtask

    task automatic pulse(input logic [63:0] m);
        @(negedge clk);
        src = m;
        @(negedge clk);
        src = '0;
        capture(m);
    endtask

    task automatic chk_read(input string req, input logic [7:0] a);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp_word(a));
    endtask

    task automatic chk_reqs(input string req);
        check(req, {31'b0, fq}, {31'b0, |(m_fast & m_en)});
        check(req, {31'b0, nq}, {31'b0, |(m_norm & m_en)});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  a;
        void'($urandom(32'd4242));
        for (int s = 0; s < 64; s++) m_prio[s] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        chk_reqs("R1 reset requests");
        foreach (a_list[i]) chk_read("R1 reset register", a_list[i]);

        // R3: routing by priority, source n of word 0 at priority n
        mwr(8'h30, 32'h7654_3210);
        pulse(64'h0000_0000_0000_00FF);
        chk_read("R3 fast word 0", 8'h00);
        chk_read("R3 normal word 0", 8'h08);
        mwr(8'h40, 32'h1111_0000);
        pulse(64'h0000_00F0_0000_0000 | 64'h0000_000F_0000_0000);
        chk_read("R3 fast word 1", 8'h04);
        chk_read("R3 normal word 1", 8'h0C);
        chk_reqs("R5 all disabled");
        chk_read("R8 entry with nothing enabled", 8'h14);

        // R5 / R7: enable gating and winner choice
        mwr(8'h18, 32'h0000_0004);
        chk_reqs("R5 single enable");
        chk_read("R7 entry single", 8'h14);
        mwr(8'h18, 32'h0000_00F3);
        chk_reqs("R5 fast enable");
        chk_read("R7 entry lowest priority value", 8'h14);

        // R7: tie goes to lower index, nonzero base
        mwr(8'h34, 32'h2222_2222);
        pulse(64'h0000_0000_0000_1200);
        mwr(8'h18, 32'h0000_FFF0);
        mwr(8'h24, 32'h1000_0000);
        chk_read("R7 tie and base", 8'h14);

        // R6: nibble packing, bit 3 reads zero
        mwr(8'h34, 32'hFFFF_FFFF);
        chk_read("R6 priority readback", 8'h34);
        chk_read("R6 priority reg 0", 8'h30);
        chk_read("R7 entry after priority change", 8'h14);

        // R4: clear semantics
        mwr(8'h08, 32'h0000_0200);
        chk_read("R4 clear one bit", 8'h08);
        mwr(8'h08, 32'h0000_0000);
        chk_read("R4 zero write keeps bits", 8'h08);
        mwr(8'h08, 32'h0000_0020);
        @(negedge clk);
        addr = 8'h08; wdata = 32'h0000_0020; we = 1'b1; src = 64'h20;
        @(negedge clk);
        we = 1'b0; src = '0;
        capture(64'h20);
        chk_read("R4 edge beats clear", 8'h08);

        // R2: held-high input does not set again after a clear
        @(negedge clk);
        src[3] = 1'b1;
        capture(64'h8);
        repeat (3) @(negedge clk);
        mwr(8'h08, 32'h0000_0008);
        repeat (3) @(negedge clk);
        chk_read("R2 no re-set while held", 8'h08);
        @(negedge clk);
        src[3] = 1'b0;

        // R9: entry write ignored, control storage
        mwr(8'h14, 32'hFFFF_FFFF);
        chk_read("R9 entry write ignored", 8'h14);
        mwr(8'h20, 32'hFFFF_FFFF);
        chk_read("R9 control readback", 8'h20);
        chk_read("R9 control no effect on entry", 8'h14);

        // R10: unmapped, misaligned, hold
        rd(8'h10, v); check("R10 unmapped read", v, 32'h0);
        rd(8'h50, v); check("R10 beyond map", v, 32'h0);
        rd(8'h31, v); check("R10 misaligned", v, 32'h0);
        rd(8'h20, v);
        mwr(8'h20, 32'h0);
        repeat (2) @(negedge clk);
        check("R10 read data holds", rdata, 32'h3);

        // R8: clear everything, entry back to base
        mwr(8'h08, 32'hFFFF_FFFF);
        mwr(8'h0C, 32'hFFFF_FFFF);
        chk_read("R8 entry equals base", 8'h14);
        chk_reqs("R5 after normal clear");

        // random traffic
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom % 7);
            case (op)
                0: pulse({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
                1: mwr(($urandom % 2) ? 8'h1C : 8'h18, $urandom);
                2: mwr(8'h30 + 8'(4 * ($urandom % 8)), $urandom);
                3: begin
                    a = 8'(4 * ($urandom % 4));
                    mwr(a, $urandom & $urandom);
                end
                4: chk_read("R7 random entry", 8'h14);
                5: begin
                    a = 8'(4 * ($urandom % 4));
                    chk_read("R3 random pending", a);
                end
                default: mwr(8'h24, $urandom);
            endcase
            chk_reqs("R5 random requests");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    logic [7:0] a_list [17] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h14, 8'h18, 8'h1C,
                                8'h20, 8'h24, 8'h30, 8'h34, 8'h38, 8'h3C, 8'h40,
                                8'h44, 8'h48, 8'h4C};

endmodule